// File: doc/BRIEF.md
# Message-Controller Interrupt Source Encoder

This block gathers service requests from a bank of message objects and one controller status source, holds each one as pending until it is explicitly cleared, and reports the single most urgent pending source as a 16-bit code in the low half of a 32-bit read word. The upper half of that word is always zero. A single interrupt line is driven from the code and a global enable bit.

Each message object has a set strobe and a clear strobe. The status source has a set strobe and is cleared as a side effect of a read of the controller's status register. Priority is fixed and does not depend on the order in which requests arrive. The status source ranks above all objects, and among the objects the lowest number wins. The code is registered, so it follows the pending set one clock later.

Top module: `can_irq_ident`

## Requirements
- R1: After reset, all pending flags are clear, `irq_word` reads 0x00000000 and `irq_line` is low.
- R2: Bits 31:16 of `irq_word` are always zero.
- R3: When only message object k (0-based index, bit k of the strobe vectors) is pending, the code in bits 15:0 is k+1, giving values 0x0001 to 0x0020.
- R4: When the status source is pending, the code is 0x8000 whatever objects are pending. No code in 0x0021..0x7FFF or 0x8001..0xFFFF is ever produced.
- R5: When only objects are pending, the code is one plus the lowest pending index, independent of arrival order.
- R6: A pending source stays pending until it is cleared. Reporting it in the code does not clear it.
- R7: A clear strobe for object k, or a status-register read for the status source, removes that source. The code then moves to the next pending source, or to 0x0000 if none remain.
- R8: When a set and a clear for the same source occur in the same cycle, the source is pending afterwards.
- R9: `irq_line` is high exactly when the code is nonzero and `irq_en` is high. Dropping `irq_en` lowers the line in the same cycle and leaves the pending sources intact.
- R10: The code reflects the pending set one clock edge after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obj_set | input | NOBJ | Per-object request strobe |
| obj_clr | input | NOBJ | Per-object clear strobe |
| stat_set | input | 1 | Status event strobe |
| stat_rd | input | 1 | Status-register read strobe; clears the status source |
| irq_en | input | 1 | Global interrupt enable |
| irq_word | output | 32 | Code in bits 15:0, zero in bits 31:16 |
| irq_line | output | 1 | Interrupt request line |

## Verification
The functions that can coincide are raising a source and removing that same source. This covers an object set strobe with its clear strobe, and a status event with a status-register read. The bench drives each object, and the status source, with both strobes in one cycle, from both the idle and the pending state. It then checks that the code one edge later still names that source. It also sweeps single and paired object requests and compares the code with one plus the lowest index, or 0x8000 when the status source is pending.

// File: rtl/can_irq_ident.sv
module can_irq_ident #(
  parameter int NOBJ = 32,
  parameter logic [15:0] STAT_CODE = 16'h8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOBJ-1:0] obj_set,
  input  logic [NOBJ-1:0] obj_clr,
  input  logic            stat_set,
  input  logic            stat_rd,
  input  logic            irq_en,
  output logic [31:0]     irq_word,
  output logic            irq_line
);
  logic [NOBJ-1:0] pend_q;
  logic            stat_q;
  logic [15:0]     code_q;
  logic [NOBJ-1:0] pend_d;
  logic            stat_d;
  logic [15:0]     code_d;

  assign pend_d = (pend_q & ~obj_clr) | obj_set;
  assign stat_d = (stat_q & ~stat_rd) | stat_set;

  always_comb begin
    code_d = 16'h0000;
    for (int i = NOBJ - 1; i >= 0; i--)
      if (pend_d[i]) code_d = 16'(i + 1);
    if (stat_d) code_d = STAT_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= 1'b0;
      code_q <= 16'h0000;
    end else begin
      pend_q <= pend_d;
      stat_q <= stat_d;
      code_q <= code_d;
    end
  end

  assign irq_word = {16'h0000, code_q};
  assign irq_line = irq_en && (code_q != 16'h0000);
endmodule

module can_irq_ident_chk #(
  parameter int NOBJ = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NOBJ-1:0] obj_set,
  input logic            stat_set,
  input logic            irq_en,
  input logic [31:0]     irq_word,
  input logic            irq_line
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_word[31:16] == 16'h0000);
  // R4
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_word[15:0] == 16'h8000 || irq_word[15:0] <= 16'(NOBJ));
  // R4
  stat_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set |=> irq_word[15:0] == 16'h8000);
  // R8
  obj_set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_set != '0) |=> irq_word[15:0] != 16'h0000);
  // R9
  line_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line == (irq_en && irq_word[15:0] != 16'h0000));
endmodule

bind can_irq_ident can_irq_ident_chk #(.NOBJ(NOBJ)) u_chk (
  .clk(clk), .rst_n(rst_n), .obj_set(obj_set), .stat_set(stat_set),
  .irq_en(irq_en), .irq_word(irq_word), .irq_line(irq_line));

// File: tb/sim_can_irq_ident.sv
module sim_can_irq_ident;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] obj_set = '0, obj_clr = '0;
  logic stat_set = 0, stat_rd = 0, irq_en = 0;
  logic [31:0] irq_word;
  logic irq_line;
  int checks = 0, fails = 0;

  can_irq_ident #(.NOBJ(N)) u0 (.*);

  always #2.5 clk = ~clk;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] s, input logic [N-1:0] c, input logic ss, input logic sr);
    @(negedge clk);
    obj_set = s; obj_clr = c; stat_set = ss; stat_rd = sr;
    @(negedge clk);
    obj_set = '0; obj_clr = '0; stat_set = 0; stat_rd = 0;
  endtask

  task automatic clear_all();
    step('0, '1, 1'b0, 1'b1);
  endtask

  initial begin
    irq_en = 1;
    repeat (3) @(negedge clk);
    chk("R1", irq_word, 0);
    chk("R1", {31'b0, irq_line}, 0);
    rst_n = 1;
    // R3: each object alone
    for (int k = 0; k < N; k++) begin
      step(N'(1) << k, '0, 0, 0);
      chk("R3", irq_word, k + 1);
      chk("R2", {16'b0, irq_word[31:16]}, 0);
      chk("R6", irq_word, k + 1);
      step('0, N'(1) << k, 0, 0);
      chk("R7", irq_word, 0);
    end
    // R5: pairs in both arrival orders
    for (int a = 0; a < N; a += 3)
      for (int b = 0; b < N; b += 5) begin
        if (a == b) continue;
        step(N'(1) << b, '0, 0, 0);
        step(N'(1) << a, '0, 0, 0);
        chk("R5", irq_word, ((a < b) ? a : b) + 1);
        step(N'(1) << ((a < b) ? a : b), '0, 0, 0);
        step('0, N'(1) << ((a < b) ? a : b), 0, 0);
        chk("R7", irq_word, ((a < b) ? b : a) + 1);
        clear_all();
      end
    // R4: status beats objects
    step(32'h0001_0000, '0, 0, 0);
    step('0, '0, 1, 0);
    chk("R4", irq_word, 32'h8000);
    step('0, '0, 0, 0);
    chk("R6", irq_word, 32'h8000);
    step('0, '0, 0, 1);
    chk("R7", irq_word, 17);
    // R9: enable gating
    irq_en = 0; #1;
    chk("R9", {31'b0, irq_line}, 0);
    irq_en = 1; #1;
    chk("R9", {31'b0, irq_line}, 1);
    chk("R9", irq_word, 17);
    clear_all();
    chk("R9", {31'b0, irq_line}, 0);
    // R8: set and clear together
    for (int k = 0; k < N; k++) begin
      step(N'(1) << k, N'(1) << k, 0, 0);
      chk("R8", irq_word, k + 1);
      step(N'(1) << k, N'(1) << k, 0, 0);
      chk("R8", irq_word, k + 1);
      clear_all();
    end
    step('0, '0, 1, 1);
    chk("R8", irq_word, 32'h8000);
    step('0, '0, 1, 1);
    chk("R8", irq_word, 32'h8000);
    clear_all();
    // R10: update timing
    @(negedge clk);
    obj_set = 32'h8000_0000;
    @(posedge clk); #1;
    chk("R10", irq_word, 32);
    obj_set = '0;
    @(negedge clk);
    clear_all();
    chk("R7", irq_word, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule